// File: doc/BRIEF.md
# UART transmitter with per-bit width trim

This block serializes one byte at a time onto an asynchronous serial line. A byte is handed over with a valid/ready handshake and waits in a one-entry holding register. When the shifter is idle, the block builds the frame from that byte and the line-format inputs. The frame is a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, and one or two high stop bits. The line rests high between frames.

Bit timing comes from a divisor. One sub-tick lasts divisor+1 clocks, and a nominal bit lasts 16 sub-ticks. A 24-bit trim word holds a 2-bit code for each of the up to 12 bit positions of a frame. The code can lengthen a bit to 17 sub-ticks or shorten it to 15, which lets the frame's total length be tuned in sixteenth-of-a-bit steps.

The format, divisor and trim word are captured when a frame starts. A break control forces the line low and holds back new frames. An empty flag shows when nothing is waiting and nothing is being sent.

Top module: `uart_tx_trim`

## Requirements
- R1: During and right after reset, tx_o is high, empty_o is high and ready_o is high.
- R2: A frame is, in order: a start bit at 0; then 5+len_i data bits, least significant bit first (len_i codes 0,1,2,3 give 5,6,7,8 bits); then the parity bit if enabled; then 1 stop bit at 1 (two_stop_i=0) or 2 stop bits (two_stop_i=1). The line is 1 when no frame is being sent.
- R3: parity_i codes 0 to 3 send no parity bit. Code 4 sends odd parity, where the data bits sent plus the parity bit hold an odd number of ones. Code 5 sends even parity. Code 6 sends a parity bit fixed at 1, and code 7 sends one fixed at 0.
- R4: With trim code 0, every bit lasts 16 sub-ticks of div_i+1 clocks, which is 16*(div_i+1) clocks.
- R5: Bit position k of a frame (k=0 is the start bit) takes its length from trim_i[2k+1:2k]. Codes 0 and 2 give 16 sub-ticks, code 1 gives 17 and code 3 gives 15. Fields for positions past the end of the frame have no effect.
- R6: A byte is taken on a rising edge where valid_i and ready_o are both high. ready_o is low while a byte is waiting. If the shifter is idle, the start bit begins on the next rising edge. A byte that arrives while a frame is running starts its start bit one clock after the previous frame's last stop bit ends.
- R7: len_i, two_stop_i, parity_i, div_i and trim_i are captured on the edge where a frame starts. Changing them during that frame does not alter it.
- R8: empty_o is high exactly when no byte is waiting and no frame is being sent.
- R9: break_i is registered. One clock after it rises while the shifter is idle, tx_o goes low. A frame already running completes unchanged, after which the line is held low. No frame starts while the break is held. After release, the line is high for one clock and then a waiting frame starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | data_i holds a byte to send |
| ready_o | output | 1 | Holding register can take a byte |
| len_i | input | 2 | Data length code, 0..3 = 5..8 bits |
| two_stop_i | input | 1 | 1 = two stop bits |
| parity_i | input | 3 | Parity mode code |
| div_i | input | DIV_W | Sub-tick length minus one, in clocks |
| trim_i | input | 24 | Per-position length codes, 2 bits each |
| break_i | input | 1 | Hold the line low instead of sending |
| tx_o | output | 1 | Serial line |
| empty_o | output | 1 | No byte waiting and shifter idle |

## Verification
Frames are compared sample by sample against a waveform computed in the bench from data, format, divisor and trim. This catches wrong bit order, a missing or wrong bit, and a bit length that is off by one sub-tick.

The patterns cover:
- 8-bit frames with no parity at several divisors, which separates divisor scaling from format errors.
- 5, 6 and 7-bit frames with each parity mode, which separates odd from even and forced-1 from forced-0, and shows that codes below 4 add no bit.
- A mixed trim word on a full 12-bit frame, which tells apart lengthened, shortened and unchanged positions.
- A trim word on a short frame, which shows that unused fields leave the frame length alone.

Two bytes are sent back to back, with the format changed mid-frame, to check the one-clock handoff gap and the capture of settings at frame start. Break is applied both while idle and mid-frame to show that it blocks new frames but never cuts a running one.

// File: rtl/uart_tx_trim_pkg.sv
package uart_tx_trim_pkg;
  localparam int DATA_W    = 8;
  localparam int FRAME_MAX = DATA_W + 4;            // start + data + parity + 2 stop
  localparam int TRIM_W    = 2 * FRAME_MAX;
  localparam int CNT_W     = $clog2(FRAME_MAX + 1);
  localparam int SUB_NOM   = 16;
  localparam int SUB_W     = $clog2(SUB_NOM + 2);

  typedef enum logic [1:0] {
    TRIM_NOM   = 2'd0,
    TRIM_LONG  = 2'd1,
    TRIM_NOP   = 2'd2,
    TRIM_SHORT = 2'd3
  } trim_code_e;

  typedef struct packed {
    logic [1:0] len;
    logic       two_stop;
    logic [2:0] parity;
  } line_cfg_t;

  function automatic logic [SUB_W-1:0] sub_len(input logic [1:0] code);
    case (trim_code_e'(code))
      TRIM_LONG:  sub_len = SUB_W'(SUB_NOM + 1);
      TRIM_SHORT: sub_len = SUB_W'(SUB_NOM - 1);
      default:    sub_len = SUB_W'(SUB_NOM);
    endcase
  endfunction
endpackage

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_tx_trim_pkg::*;
(
  input  logic [DATA_W-1:0]    data_i,
  input  line_cfg_t            cfg_i,
  output logic [FRAME_MAX-1:0] bits_o,
  output logic [CNT_W-1:0]     nbits_o
);
  logic [FRAME_MAX-1:0] dsh;
  logic [DATA_W-1:0]    dm;
  logic                 par_en, par_bit;
  int                   nd;

  always_comb begin
    nd      = 5 + int'(cfg_i.len);
    dm      = data_i & ({DATA_W{1'b1}} >> (2'd3 - cfg_i.len));
    dsh     = {{(FRAME_MAX-DATA_W-1){1'b0}}, data_i, 1'b0};
    par_en  = cfg_i.parity[2];
    case (cfg_i.parity[1:0])
      2'd0:    par_bit = ~^dm;
      2'd1:    par_bit = ^dm;
      2'd2:    par_bit = 1'b1;
      default: par_bit = 1'b0;
    endcase
    for (int i = 0; i < FRAME_MAX; i++) begin
      if (i == 0)                      bits_o[i] = 1'b0;
      else if (i <= nd)                bits_o[i] = dsh[i];
      else if (par_en && i == nd + 1)  bits_o[i] = par_bit;
      else                             bits_o[i] = 1'b1;
    end
    nbits_o = CNT_W'(2 + nd + int'(par_en) + int'(cfg_i.two_stop));
  end
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic         take_i,
  output logic         pend_o,
  output logic [W-1:0] data_o
);
  logic         pend_q;
  logic [W-1:0] data_q;

  assign ready_o = !pend_q;
  assign pend_o  = pend_q;
  assign data_o  = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (valid_i && !pend_q) begin
      pend_q <= 1'b1;
      data_q <= data_i;
    end else if (take_i) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_tick.sv
module uart_tx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;

  assign tick_o = !clr_i && (pre_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      pre_q <= '0;
    else if (clr_i || pre_q == div_i) pre_q <= '0;
    else                              pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_trim_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [FRAME_MAX-1:0] bits_i,
  input  logic [CNT_W-1:0]     nbits_i,
  input  logic [TRIM_W-1:0]    trim_i,
  input  logic                 tick_i,
  output logic                 busy_o,
  output logic                 line_o
);
  logic                 busy_q;
  logic [FRAME_MAX-1:0] sh_q;
  logic [TRIM_W-1:0]    trim_q;
  logic [CNT_W-1:0]     left_q;
  logic [SUB_W-1:0]     sub_q, sub_end;

  assign busy_o  = busy_q;
  assign line_o  = sh_q[0];
  assign sub_end = sub_len(trim_q[1:0]) - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      trim_q <= '0;
      left_q <= '0;
      sub_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      sh_q   <= bits_i;
      trim_q <= trim_i;
      left_q <= nbits_i - 1'b1;
      sub_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (sub_q == sub_end) begin
        sub_q  <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
        trim_q <= {2'b00, trim_q[TRIM_W-1:2]};
        if (left_q == '0) busy_q <= 1'b0;
        else              left_q <= left_q - 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_trim.sv
module uart_tx_trim
  import uart_tx_trim_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [1:0]        len_i,
  input  logic              two_stop_i,
  input  logic [2:0]        parity_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [TRIM_W-1:0] trim_i,
  input  logic              break_i,
  output logic              tx_o,
  output logic              empty_o
);
  logic                 pend, busy, load, tick, line, brk_q;
  logic [DATA_W-1:0]    pdata;
  logic [FRAME_MAX-1:0] fbits;
  logic [CNT_W-1:0]     fnbits;
  logic [DIV_W-1:0]     div_q;
  line_cfg_t            cfg;

  assign cfg     = '{len: len_i, two_stop: two_stop_i, parity: parity_i};
  assign load    = !busy && pend && !brk_q;
  assign tx_o    = busy ? line : !brk_q;
  assign empty_o = !pend && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      brk_q <= 1'b0;
      div_q <= '0;
    end else begin
      brk_q <= break_i;
      if (load) div_q <= div_i;
    end
  end

  uart_tx_hold #(.W(DATA_W)) u_hold (
    .clk_i, .rst_ni, .data_i, .valid_i, .ready_o,
    .take_i(load), .pend_o(pend), .data_o(pdata)
  );

  uart_tx_frame u_frame (
    .data_i(pdata), .cfg_i(cfg), .bits_o(fbits), .nbits_o(fnbits)
  );

  uart_tx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .clr_i(!busy), .div_i(div_q), .tick_o(tick)
  );

  uart_tx_shift u_shift (
    .clk_i, .rst_ni, .load_i(load), .bits_i(fbits), .nbits_i(fnbits),
    .trim_i, .tick_i(tick), .busy_o(busy), .line_o(line)
  );
endmodule

// File: rtl/uart_tx_trim_chk.sv
module uart_tx_trim_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic valid_i,
  input logic ready_o,
  input logic break_i,
  input logic tx_o,
  input logic empty_o,
  input logic busy_i,
  input logic brk_i,
  input logic tick_i
);
  p_taken_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

  p_empty_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (ready_o && !busy_i));

  p_start_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> !tx_o);

  p_hold_subtick_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !tick_i) |=> $stable(tx_o));

  p_break_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (break_i && empty_o) |=> !tx_o);

  p_no_start_in_break_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brk_i && !busy_i) |=> !busy_i);
endmodule

bind uart_tx_trim uart_tx_trim_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
  .break_i(break_i), .tx_o(tx_o), .empty_o(empty_o),
  .busy_i(busy), .brk_i(brk_q), .tick_i(tick)
);

// File: tb/uart_tx_trim_tb.sv
`timescale 1ns/1ps
module uart_tx_trim_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  data_i = '0;
  logic        valid_i = 1'b0;
  logic        ready_o;
  logic [1:0]  len_i = 2'd3;
  logic        two_stop_i = 1'b0;
  logic [2:0]  parity_i = 3'd0;
  logic [15:0] div_i = '0;
  logic [23:0] trim_i = '0;
  logic        break_i = 1'b0;
  logic        tx_o, empty_o;

  int n_chk = 0, n_err = 0;
  logic exp_w [0:8191];
  int   exp_n = 0;

  always #10 clk = ~clk;

  uart_tx_trim u_dut (
    .clk_i(clk), .rst_ni, .data_i, .valid_i, .ready_o, .len_i, .two_stop_i,
    .parity_i, .div_i, .trim_i, .break_i, .tx_o, .empty_o
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic add_level(input logic v, input int c);
    for (int i = 0; i < c; i++) begin
      exp_w[exp_n] = v;
      exp_n++;
    end
  endtask

  // expected waveform of one frame from the current format inputs
  task automatic add_frame(input logic [7:0] d, input int div, input logic [23:0] trim);
    logic fb [0:11];
    int   nd, n, ones, L;
    logic [1:0] code;
    nd = 5 + int'(len_i);
    fb[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < nd; i++) begin
      fb[1+i] = d[i];
      if (d[i]) ones++;
    end
    n = 1 + nd;
    if (parity_i >= 3'd4) begin
      case (parity_i)
        3'd4: fb[n] = (ones % 2 == 0);
        3'd5: fb[n] = (ones % 2 == 1);
        3'd6: fb[n] = 1'b1;
        default: fb[n] = 1'b0;
      endcase
      n++;
    end
    fb[n] = 1'b1; n++;
    if (two_stop_i) begin fb[n] = 1'b1; n++; end
    for (int k = 0; k < n; k++) begin
      code = trim[2*k +: 2];
      L = (code == 2'd1) ? 17 : (code == 2'd3) ? 15 : 16;
      add_level(fb[k], L * (div + 1));
    end
  endtask

  // compare tx_o against exp_w, one sample per falling edge, starting now
  task automatic watch(input string tag);
    int   bad = -1;
    logic gv = 1'b0, ev = 1'b0;
    for (int i = 0; i < exp_n; i++) begin
      if (bad < 0 && tx_o !== exp_w[i]) begin
        bad = i; gv = tx_o; ev = exp_w[i];
      end
      @(negedge clk);
    end
    n_chk++;
    if (bad >= 0) begin
      n_err++;
      $display("FAIL %s: tx_o sample %0d got %b expected %b", tag, bad, gv, ev);
    end
    exp_n = 0;
  endtask

  // at a falling edge: hand over a byte, return at the next falling edge
  task automatic send(input logic [7:0] d);
    data_i = d; valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic one_frame(input string tag, input logic [7:0] d);
    add_level(1'b1, 1);
    add_frame(d, int'(div_i), trim_i);
    add_level(1'b1, 3);
    send(d);
    watch(tag);
    chk({tag, " empty after frame (R8)"}, empty_o, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1 tx_o in reset", tx_o, 1'b1);
    chk("R1 empty_o in reset", empty_o, 1'b1);
    chk("R1 ready_o in reset", ready_o, 1'b1);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 tx_o after reset", tx_o, 1'b1);
  endtask

  task automatic t_basic;
    len_i = 2'd3; two_stop_i = 1'b0; parity_i = 3'd0; trim_i = '0;
    div_i = 16'd0; one_frame("R2 R4 8N1 div0", 8'hA5);
    div_i = 16'd3; one_frame("R4 8N1 div3", 8'h3C);
  endtask

  task automatic t_parity;
    div_i = 16'd2; trim_i = '0;
    len_i = 2'd0; two_stop_i = 1'b1; parity_i = 3'd5; one_frame("R3 5E2 even", 8'hF3);
    len_i = 2'd2; two_stop_i = 1'b0; parity_i = 3'd4; one_frame("R3 7O1 odd", 8'h5A);
    len_i = 2'd1; parity_i = 3'd6; one_frame("R3 6 forced one", 8'h80);
    len_i = 2'd1; parity_i = 3'd7; one_frame("R3 6 forced zero", 8'h3F);
    len_i = 2'd3; parity_i = 3'd2; one_frame("R3 code2 no parity", 8'h01);
  endtask

  task automatic t_trim;
    logic [23:0] t = '0;
    for (int k = 0; k < 12; k++) t[2*k +: 2] = 2'((k * 3 + 1) % 4);
    div_i = 16'd1; len_i = 2'd3; two_stop_i = 1'b1; parity_i = 3'd5; trim_i = t;
    one_frame("R5 12-bit frame mixed trim", 8'hC6);
    t = '0;
    for (int k = 0; k < 12; k++) t[2*k +: 2] = (k < 7) ? 2'd1 : 2'd3;
    len_i = 2'd0; two_stop_i = 1'b0; parity_i = 3'd0; trim_i = t;
    one_frame("R5 short frame unused fields", 8'h15);
  endtask

  task automatic t_queue;
    len_i = 2'd3; two_stop_i = 1'b0; parity_i = 3'd4; div_i = 16'd1; trim_i = 24'h00_0C_41;
    add_level(1'b1, 1);
    add_frame(8'h96, 1, 24'h00_0C_41);
    add_level(1'b1, 1);
    len_i = 2'd1; two_stop_i = 1'b1; parity_i = 3'd7;
    add_frame(8'h2B, 2, 24'hFF_FF_FF);
    add_level(1'b1, 3);
    len_i = 2'd3; two_stop_i = 1'b0; parity_i = 3'd4;
    data_i = 8'h96; valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    data_i = 8'h2B;
    fork
      watch("R6 R7 back-to-back frames");
      begin
        chk("R6 ready_o low while byte waits", ready_o, 1'b0);
        chk("R8 empty_o low while byte waits", empty_o, 1'b0);
        @(negedge clk);
        len_i = 2'd1; two_stop_i = 1'b1; parity_i = 3'd7; div_i = 16'd2; trim_i = 24'hFF_FF_FF;
        chk("R6 ready_o back once frame starts", ready_o, 1'b1);
        @(posedge clk);
        @(negedge clk);
        valid_i = 1'b0;
        chk("R8 empty_o low while sending", empty_o, 1'b0);
      end
    join
    chk("R8 empty after both frames", empty_o, 1'b1);
  endtask

  task automatic t_break_idle;
    len_i = 2'd3; two_stop_i = 1'b0; parity_i = 3'd0; div_i = 16'd0; trim_i = '0;
    break_i = 1'b1;
    @(negedge clk);
    chk("R9 line low on idle break", tx_o, 1'b0);
    send(8'h69);
    add_level(1'b0, 40);
    watch("R9 no frame while break held");
    chk("R9 byte still waiting in break", ready_o, 1'b0);
    chk("R9 not empty in break", empty_o, 1'b0);
    break_i = 1'b0;
    add_level(1'b0, 1);
    add_level(1'b1, 1);
    add_frame(8'h69, 0, '0);
    add_level(1'b1, 3);
    watch("R9 frame after break release");
  endtask

  task automatic t_break_mid;
    len_i = 2'd2; two_stop_i = 1'b1; parity_i = 3'd5; div_i = 16'd0; trim_i = 24'h00_00_31;
    add_level(1'b1, 1);
    add_frame(8'h4E, 0, 24'h00_00_31);
    add_level(1'b0, 3);
    data_i = 8'h4E; valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    valid_i = 1'b0;
    fork
      watch("R9 running frame completes under break");
      begin
        repeat (10) @(negedge clk);
        break_i = 1'b1;
      end
    join
    break_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 line high after release", tx_o, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_parity();
    t_trim();
    t_queue();
    t_break_idle();
    t_break_mid();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule